// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the software-facing half of an eight-line priority interrupt controller. A byte-wide register port with one address bit accepts initialization words, operation words and mask loads, and returns the mask, the in-service set, the live request set, or a polled line number. The block holds the mask, the in-service set, the base vector, the rotating priority offset and the mode flags. It resolves the highest-priority unmasked request against the in-service set internally.

The raw request set comes from outside on `irr_i`. The block raises `int_o` when a request outranks everything in service. During an acknowledge strobe it presents the vector and updates the in-service set. It pulses `req_clr_o` for the served line, so that the external request logic can drop edge-type requests. Priority is rotational: the line equal to the offset has rank 0, and rank rises with distance from the offset, modulo 8. Several end-of-interrupt flavours can clear in-service lines and move the offset.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the in-service set, mask, base vector, offset and all mode flags are zero. Address-0 reads return `irr_i`. `nested_o` and `smask_o` are low.
- R2: A write to address 0 with bit 4 set is an init word. It clears the mask, in-service set, offset, rotate flag, readback select, poll flag, special-mask flag, base vector, nested flag and auto-EOI flag. It stores bit 0 as "config word 4 follows".
- R3: Address-1 writes depend on the sequence state. In run state the data loads the mask. The first write after an init word loads the base vector, which is the data with its low 3 bits cleared. The second write returns to run state unless config word 4 was announced. That third write then sets the nested flag from bit 4 and auto-EOI from bit 1, and returns to run state.
- R4: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode word. Bit 2 = 1 arms a poll. Bit 1 = 1 loads readback select from bit 0, where 1 selects the in-service set and 0 selects requests. Bit 6 = 1 loads the special-mask flag from bit 5. A flag whose enable bit is 0 keeps its value.
- R5: The winning request is the lowest-rank line in `irr_i & ~mask`. Rank is (line − offset) mod 8. `int_o` is high exactly when that rank is below the rank of the lowest-rank in-service line, or when a winner exists and the in-service set is empty.
- R6: An address-0 write with bits 4:3 = 00 is a command, and bits 7:5 give its code. Code 1 clears the lowest-rank in-service line. Code 5 does the same and sets the offset to that line + 1. Neither code has any effect when the in-service set is empty.
- R7: Code 3 clears the in-service bit of line data[2:0]. Code 7 does the same and sets the offset to data[2:0] + 1.
- R8: Code 6 sets the offset to data[2:0] + 1 (mod 8). Codes 0 and 4 set the rotate-on-auto-EOI flag to bit 7 of the data. Code 2 changes nothing.
- R9: While `inta_i` is high, `vector_o` is the base vector + served line. At that edge the served line's in-service bit is set, and `req_clr_o` is its one-hot. With no winner the line is 7, the in-service set is unchanged and `req_clr_o` is zero.
- R10: In auto-EOI mode an acknowledge leaves the in-service set unchanged. If the rotate flag is also set, the offset becomes the served line + 1.
- R11: Without a pending poll, an address-1 read returns the mask. An address-0 read returns the in-service set or `irr_i`, according to the readback select.
- R12: With a poll armed, the next read of either address returns the winning line number, or 7 if there is no winner. It clears that line's in-service bit, pulses `req_clr_o` for it, and disarms the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| rd_en_i | input | 1 | Single-cycle register read strobe |
| addr_i | input | 1 | Register port address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid while `rd_en_i` is high |
| irr_i | input | NLINES | Request set from the external request logic |
| inta_i | input | 1 | Single-cycle acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| vector_o | output | DW | Acknowledge vector, valid while `inta_i` is high |
| req_clr_o | output | NLINES | One-hot request clear for a served or polled line |
| isr_o | output | NLINES | In-service set |
| nested_o | output | 1 | Nested-mode flag from config word 4 |
| smask_o | output | 1 | Special-mask flag |

## Verification
`rdata_o`, `vector_o` and `req_clr_o` are combinational from the strobe, so each is due in the same cycle as the strobe. The bench samples them 1 ns after driving the strobe, which is still before the capturing edge. The in-service set, the mode flags and any offset change take effect at that edge. The bench therefore compares `isr_o`, `int_o`, `nested_o` and `smask_o` at the following falling edge, against a bench model that was updated at the edge. Changes on `irr_i` alone reach `int_o` without a clock, and they are checked before the next edge.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

   // Address-1 write sequence states
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_BASE = 2'd1,
      ST_CFG2 = 2'd2,
      ST_CFG3 = 2'd3
   } init_st_e;

   // Command codes carried in data bits 7:5 of a command write
   typedef enum logic [2:0] {
      OP_ROT_CLR  = 3'd0,
      OP_EOI      = 3'd1,
      OP_NOP      = 3'd2,
      OP_EOI_SPEC = 3'd3,
      OP_ROT_SET  = 3'd4,
      OP_EOI_ROT  = 3'd5,
      OP_SET_OFF  = 3'd6,
      OP_SPEC_ROT = 3'd7
   } ocw_op_e;

endpackage

// File: rtl/pic_prio_scan.sv
// Rotating priority scan: finds the lowest-rank set bit of a line vector,
// where rank = (line - offset) mod NLINES.
module pic_prio_scan #(
   parameter int NLINES = 8,
   parameter int LW     = $clog2(NLINES)
) (
   input  logic [NLINES-1:0] vec_i,
   input  logic [LW-1:0]     off_i,
   output logic              found_o,
   output logic [LW-1:0]     line_o,
   output logic [LW:0]       rank_o
);

   logic [NLINES-1:0] rot;

   // rot[k] is the line whose rank is k
   for (genvar g = 0; g < NLINES; g++) begin : g_rot
      logic [LW-1:0] src;
      assign src    = LW'(g) + off_i;
      assign rot[g] = vec_i[src];
   end

   always_comb begin
      rank_o = (LW+1)'(NLINES);
      for (int i = NLINES - 1; i >= 0; i--) begin
         if (rot[i]) rank_o = (LW+1)'(i);
      end
   end

   assign found_o = |vec_i;
   assign line_o  = rank_o[LW-1:0] + off_i;

   // R5: the reported line is really present in the scanned vector
   always_comb begin
      if (found_o) begin
         p_line_live_r5: assert (vec_i[line_o]);
      end
   end

endmodule

// File: rtl/pic_init_seq.sv
// Address-1 write sequencer: base vector, config words and mask-load gating.
module pic_init_seq
   import pic_seq_pkg::*;
#(
   parameter int DW = 8,
   parameter int LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          cfg_wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          mask_wr_o,
   output logic [DW-1:0] base_o,
   output logic          nested_o,
   output logic          auto_eoi_o
);

   init_st_e      st_q;
   logic          four_q;
   logic [DW-1:0] base_q;
   logic          nested_q;
   logic          aeoi_q;
   logic          unused_wd;

   assign unused_wd = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_RUN;
         four_q   <= 1'b0;
         base_q   <= '0;
         nested_q <= 1'b0;
         aeoi_q   <= 1'b0;
      end else if (start_i) begin
         st_q     <= ST_BASE;
         four_q   <= wdata_i[0];
         base_q   <= '0;
         nested_q <= 1'b0;
         aeoi_q   <= 1'b0;
      end else if (cfg_wr_i) begin
         unique case (st_q)
            ST_RUN: begin
            end
            ST_BASE: begin
               base_q <= {wdata_i[DW-1:LW], {LW{1'b0}}};
               st_q   <= ST_CFG2;
            end
            ST_CFG2: begin
               st_q <= four_q ? ST_CFG3 : ST_RUN;
            end
            ST_CFG3: begin
               nested_q <= wdata_i[4];
               aeoi_q   <= wdata_i[1];
               st_q     <= ST_RUN;
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign mask_wr_o  = cfg_wr_i && (st_q == ST_RUN);
   assign base_o     = base_q;
   assign nested_o   = nested_q;
   assign auto_eoi_o = aeoi_q;

   // R3: base word always advances to the second config step
   p_base_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BASE && cfg_wr_i && !start_i) |=> (st_q == ST_CFG2));

   // R3: without word 4 announced, the second config step ends the sequence
   p_cfg_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CFG2 && cfg_wr_i && !start_i && !four_q) |=> (st_q == ST_RUN));

   // R2: an init word always restarts the sequence
   p_init_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (st_q == ST_BASE && !nested_q && !aeoi_q));

endmodule

// File: rtl/pic_cmd_seq.sv
// Command sequencer of an eight-line rotating-priority interrupt controller.
module pic_cmd_seq
   import pic_seq_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic              addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   input  logic [NLINES-1:0] irr_i,
   input  logic              inta_i,
   output logic              int_o,
   output logic [DW-1:0]     vector_o,
   output logic [NLINES-1:0] req_clr_o,
   output logic [NLINES-1:0] isr_o,
   output logic              nested_o,
   output logic              smask_o
);

   localparam int LW = $clog2(NLINES);
   localparam logic [LW-1:0] LAST_LINE = LW'(NLINES - 1);

   // elaboration-time parameter checks
   if (DW < 8) begin : g_dw_chk
      $error("pic_cmd_seq: DW must be at least 8");
   end
   if (NLINES < 2 || NLINES > 8 || (NLINES & (NLINES - 1)) != 0) begin : g_nl_chk
      $error("pic_cmd_seq: NLINES must be 2, 4 or 8");
   end

   // write decode
   logic wr0, wr1, init_wr, mode_wr, cmd_wr, mask_wr, poll_rd;
   ocw_op_e op;
   logic [LW-1:0] lsel;

   assign wr0     = wr_en_i && !addr_i;
   assign wr1     = wr_en_i && addr_i;
   assign init_wr = wr0 && wdata_i[4];
   assign mode_wr = wr0 && !wdata_i[4] && wdata_i[3];
   assign cmd_wr  = wr0 && !wdata_i[4] && !wdata_i[3];
   assign op      = ocw_op_e'(wdata_i[7:5]);
   assign lsel    = wdata_i[LW-1:0];

   // state
   logic [NLINES-1:0] imr_q, imr_n;
   logic [NLINES-1:0] isr_q, isr_n;
   logic [LW-1:0]     off_q, off_n;
   logic              rot_q, rot_n;
   logic              rsel_q, rsel_n;
   logic              poll_q, poll_n;
   logic              smask_q, smask_n;

   logic [DW-1:0]     base;
   logic              auto_eoi;

   pic_init_seq #(.DW(DW), .LW(LW)) u_init (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (init_wr),
      .cfg_wr_i   (wr1),
      .wdata_i    (wdata_i),
      .mask_wr_o  (mask_wr),
      .base_o     (base),
      .nested_o   (nested_o),
      .auto_eoi_o (auto_eoi)
   );

   // resolvers: pending requests and in-service lines
   logic [NLINES-1:0] pend;
   logic              req_found, svc_found;
   logic [LW-1:0]     req_line, svc_line;
   logic [LW:0]       req_rank, svc_rank;
   logic              win;
   logic [LW-1:0]     served;

   assign pend = irr_i & ~imr_q;

   pic_prio_scan #(.NLINES(NLINES), .LW(LW)) u_req_scan (
      .vec_i   (pend),
      .off_i   (off_q),
      .found_o (req_found),
      .line_o  (req_line),
      .rank_o  (req_rank)
   );

   pic_prio_scan #(.NLINES(NLINES), .LW(LW)) u_svc_scan (
      .vec_i   (isr_q),
      .off_i   (off_q),
      .found_o (svc_found),
      .line_o  (svc_line),
      .rank_o  (svc_rank)
   );

   assign win     = req_found && (req_rank < svc_rank);
   assign served  = win ? req_line : LAST_LINE;
   assign poll_rd = rd_en_i && poll_q;

   assign int_o     = win;
   assign vector_o  = base | DW'(served);
   assign req_clr_o = ((inta_i || poll_rd) && win) ? (NLINES'(1) << req_line) : '0;
   assign isr_o     = isr_q;
   assign smask_o   = smask_q;

   // readback
   always_comb begin
      if (poll_rd)      rdata_o = DW'(served);
      else if (addr_i)  rdata_o = DW'(imr_q);
      else if (rsel_q)  rdata_o = DW'(isr_q);
      else              rdata_o = DW'(irr_i);
   end

   // next state: strobes are mutually exclusive, the order below resolves overlap
   always_comb begin
      isr_n   = isr_q;
      imr_n   = imr_q;
      off_n   = off_q;
      rot_n   = rot_q;
      rsel_n  = rsel_q;
      poll_n  = poll_q;
      smask_n = smask_q;
      if (init_wr) begin
         isr_n   = '0;
         imr_n   = '0;
         off_n   = '0;
         rot_n   = 1'b0;
         rsel_n  = 1'b0;
         poll_n  = 1'b0;
         smask_n = 1'b0;
      end else if (cmd_wr) begin
         unique case (op)
            OP_ROT_CLR, OP_ROT_SET: rot_n = wdata_i[7];
            OP_EOI, OP_EOI_ROT: begin
               if (svc_found) begin
                  isr_n[svc_line] = 1'b0;
                  if (op == OP_EOI_ROT) off_n = svc_line + LW'(1);
               end
            end
            OP_EOI_SPEC: isr_n[lsel] = 1'b0;
            OP_SET_OFF:  off_n = lsel + LW'(1);
            OP_SPEC_ROT: begin
               isr_n[lsel] = 1'b0;
               off_n       = lsel + LW'(1);
            end
            default: begin
            end
         endcase
      end else if (mode_wr) begin
         if (wdata_i[2]) poll_n  = 1'b1;
         if (wdata_i[1]) rsel_n  = wdata_i[0];
         if (wdata_i[6]) smask_n = wdata_i[5];
      end else if (mask_wr) begin
         imr_n = wdata_i[NLINES-1:0];
      end else if (poll_rd) begin
         poll_n = 1'b0;
         if (win) isr_n[req_line] = 1'b0;
      end else if (inta_i && win) begin
         if (!auto_eoi)  isr_n[req_line] = 1'b1;
         else if (rot_q) off_n = req_line + LW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q   <= '0;
         imr_q   <= '0;
         off_q   <= '0;
         rot_q   <= 1'b0;
         rsel_q  <= 1'b0;
         poll_q  <= 1'b0;
         smask_q <= 1'b0;
      end else begin
         isr_q   <= isr_n;
         imr_q   <= imr_n;
         off_q   <= off_n;
         rot_q   <= rot_n;
         rsel_q  <= rsel_n;
         poll_q  <= poll_n;
         smask_q <= smask_n;
      end
   end

   // R9: the strobes are used one at a time
   p_single_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en_i, rd_en_i, inta_i}));

   // R2: an init word empties in-service set, mask and poll flag
   p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> (isr_q == '0 && imr_q == '0 && !poll_q));

   // R5: an interrupt request needs an unmasked request line
   p_int_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((irr_i & ~imr_q) != '0));

   // R9: a normal acknowledge marks the served line in service
   p_ack_sets_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_i && int_o && !auto_eoi) |=> ((isr_q & $past(req_clr_o)) != '0));

   // R10: in auto-EOI mode an acknowledge never adds an in-service line
   p_aeoi_no_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_i && auto_eoi) |=> ((isr_q & ~$past(isr_q)) == '0));

   // R7: a specific clear leaves the named line out of service
   p_spec_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (op == OP_EOI_SPEC || op == OP_SPEC_ROT)) |=> !isr_q[$past(lsel)]);

   // R12: any read disarms a pending poll
   p_poll_disarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && poll_q) |=> !poll_q);

   // R12: request clears name at most one line
   p_clr_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_clr_o));

endmodule

// File: tb/pic_cmd_seq_bench.sv
module pic_cmd_seq_bench;

   localparam int NL = 8;
   localparam int DW = 8;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       addr  = 1'b0;
   logic       inta  = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] irr   = 8'h00;
   logic [7:0] rdata, vector, req_clr, isr;
   logic       int_w, nested, smask;

   always #2 clk = ~clk;

   pic_cmd_seq #(.NLINES(NL), .DW(DW)) u_pic_cmd_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .rd_en_i   (rd_en),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .irr_i     (irr),
      .inta_i    (inta),
      .int_o     (int_w),
      .vector_o  (vector),
      .req_clr_o (req_clr),
      .isr_o     (isr),
      .nested_o  (nested),
      .smask_o   (smask)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [7:0] m_imr = 0, m_isr = 0, m_base = 0;
   logic [2:0] m_off = 0;
   bit m_rot = 0, m_aeoi = 0, m_sfnm = 0, m_smask = 0, m_rsel = 0, m_poll = 0, m_four = 0;
   int m_st = 0;

   function automatic int top_rank(logic [7:0] v);
      for (int r = 0; r < 8; r++) begin
         if (v[(r + int'(m_off)) % 8]) return r;
      end
      return 8;
   endfunction

   function automatic int win_line();
      int rq;
      int rs;
      rq = top_rank(irr & ~m_imr);
      rs = top_rank(m_isr);
      if (rq < rs) return (rq + int'(m_off)) % 8;
      return -1;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag);
      chk({tag, " isr (R9)"},      32'(isr),    32'(m_isr));
      chk({tag, " int (R5)"},      32'(int_w),  (win_line() >= 0) ? 32'd1 : 32'd0);
      chk({tag, " nested (R3)"},   32'(nested), 32'(m_sfnm));
      chk({tag, " smask (R4)"},    32'(smask),  32'(m_smask));
   endtask

   task automatic m_clear();
      m_imr = 0; m_isr = 0; m_base = 0; m_off = 0;
      m_rot = 0; m_aeoi = 0; m_sfnm = 0; m_smask = 0; m_rsel = 0; m_poll = 0;
   endtask

   task automatic m_wr(bit a, logic [7:0] d);
      int r;
      int l;
      if (!a) begin
         if (d[4]) begin
            m_clear();
            m_four = d[0];
            m_st   = 1;
         end else if (d[3]) begin
            if (d[2]) m_poll = 1;
            if (d[1]) m_rsel = d[0];
            if (d[6]) m_smask = d[5];
         end else begin
            case (d[7:5])
               3'd0, 3'd4: m_rot = d[7];
               3'd1, 3'd5: begin
                  r = top_rank(m_isr);
                  if (r < 8) begin
                     l = (r + int'(m_off)) % 8;
                     m_isr[l] = 1'b0;
                     if (d[7:5] == 3'd5) m_off = 3'(l + 1);
                  end
               end
               3'd3: m_isr[d[2:0]] = 1'b0;
               3'd6: m_off = d[2:0] + 3'd1;
               3'd7: begin
                  m_isr[d[2:0]] = 1'b0;
                  m_off = d[2:0] + 3'd1;
               end
               default: ;
            endcase
         end
      end else begin
         case (m_st)
            0: m_imr = d;
            1: begin m_base = d & 8'hF8; m_st = 2; end
            2: m_st = m_four ? 3 : 0;
            default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_st = 0; end
         endcase
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic do_wr(bit a, logic [7:0] d, string tag);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      m_wr(a, d);
      @(negedge clk);
      wr_en = 1'b0;
      chk_state(tag);
   endtask

   task automatic do_rd(bit a, string tag);
      int w;
      logic [7:0] exp;
      logic [7:0] clr;
      rd_en = 1'b1; addr = a;
      #1;
      w = win_line();
      clr = 8'h00;
      if (m_poll) begin
         exp = (w >= 0) ? 8'(w) : 8'd7;
         if (w >= 0) clr = 8'(1 << w);
      end else if (a) exp = m_imr;
      else exp = m_rsel ? m_isr : irr;
      chk({tag, " rdata"},   32'(rdata),   32'(exp));
      chk({tag, " req_clr"}, 32'(req_clr), 32'(clr));
      @(posedge clk);
      if (m_poll) begin
         if (w >= 0) m_isr[w] = 1'b0;
         m_poll = 0;
      end
      @(negedge clk);
      rd_en = 1'b0;
      chk_state(tag);
   endtask

   task automatic do_ack(string tag);
      int w;
      int l;
      inta = 1'b1;
      #1;
      w = win_line();
      l = (w >= 0) ? w : 7;
      chk({tag, " vector"},  32'(vector),  32'(m_base + 8'(l)));
      chk({tag, " req_clr"}, 32'(req_clr), (w >= 0) ? 32'(1 << w) : 32'd0);
      @(posedge clk);
      if (w >= 0) begin
         if (!m_aeoi) m_isr[w] = 1'b1;
         else if (m_rot) m_off = 3'(w + 1);
      end
      @(negedge clk);
      inta = 1'b0;
      chk_state(tag);
   endtask

   task automatic set_irr(logic [7:0] v, string tag);
      irr = v;
      #1;
      chk({tag, " int"}, 32'(int_w), (win_line() >= 0) ? 32'd1 : 32'd0);
      @(negedge clk);
   endtask

   task automatic do_init(logic [7:0] b, bit four, logic [7:0] cfg, string tag);
      do_wr(1'b0, 8'h10 | 8'(four), tag);
      do_wr(1'b1, b, tag);
      do_wr(1'b1, 8'h00, tag);
      if (four) do_wr(1'b1, cfg, tag);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 190000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_state("R1 reset");
      do_rd(1'b1, "R1 mask after reset");
      set_irr(8'h24, "R1 request");
      do_rd(1'b0, "R1 R11 request readback");

      // R3 init without word 4, then mask load
      do_init(8'h25, 1'b0, 8'h00, "R3 init three words");
      do_wr(1'b1, 8'hF0, "R3 mask load");
      do_rd(1'b1, "R11 mask read");
      do_ack("R9 ack line 2");
      do_ack("R9 spurious ack");

      // R4 readback select and special mask
      do_wr(1'b0, 8'h0B, "R4 select isr");
      do_rd(1'b0, "R11 isr read");
      do_wr(1'b0, 8'h0A, "R4 select irr");
      do_rd(1'b0, "R11 irr read");
      do_wr(1'b0, 8'h68, "R4 smask set");
      do_wr(1'b0, 8'h28, "R4 smask hold");
      do_wr(1'b0, 8'h48, "R4 smask clear");

      // R6 nonspecific EOI and the empty case
      do_wr(1'b0, 8'h20, "R6 eoi");
      do_wr(1'b0, 8'h20, "R6 eoi empty");

      // R2 R3 init with word 4, auto-EOI
      do_wr(1'b1, 8'h81, "R3 mask before reinit");
      do_init(8'h48, 1'b1, 8'h12, "R3 init four words");
      do_rd(1'b1, "R2 mask cleared");
      do_ack("R10 aeoi ack");
      do_wr(1'b0, 8'h80, "R8 rotate flag on");
      do_ack("R10 aeoi rotate");
      do_ack("R10 after rotation");
      do_wr(1'b0, 8'h00, "R8 rotate flag off");

      // R2 reinit clears modes; EOI variants
      do_init(8'h08, 1'b1, 8'h00, "R2 reinit");
      set_irr(8'hFF, "R5 all requests");
      do_ack("R9 ack line 0");
      do_wr(1'b0, 8'hC3, "R8 set offset");
      do_ack("R9 ack after offset");
      do_wr(1'b0, 8'h20, "R6 nonspecific");
      do_wr(1'b0, 8'hA0, "R6 rotating eoi");
      do_ack("R9 ack rotated");
      do_wr(1'b0, 8'h40, "R8 no-op command");
      do_wr(1'b0, 8'h61, "R7 specific clear");
      do_ack("R9 ack again");
      do_wr(1'b0, 8'hE1, "R7 specific rotate");
      do_ack("R7 next winner");

      // R12 poll
      do_wr(1'b0, 8'h0C, "R4 poll arm");
      do_rd(1'b1, "R12 poll no winner");
      do_rd(1'b1, "R12 poll disarmed");
      do_wr(1'b0, 8'h20, "R6 eoi before poll");
      do_wr(1'b0, 8'h0C, "R4 poll arm again");
      do_rd(1'b0, "R12 poll winner");

      // random phase
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         k = $urandom_range(0, 99);
         if (k < 15) begin
            set_irr(8'($urandom()) & 8'($urandom()), "R5 random request");
         end else if (k < 35) begin
            do_ack("R9 R10 random ack");
         end else if (k < 60) begin
            d = {3'($urandom()), 2'b00, 3'($urandom())};
            do_wr(1'b0, d, "R6 R7 R8 random command");
         end else if (k < 70) begin
            d = {1'b0, 2'($urandom()), 2'b01, 3'($urandom())};
            do_wr(1'b0, d, "R4 random mode word");
         end else if (k < 85) begin
            do_rd(1'($urandom()), "R11 R12 random read");
         end else if (k < 97) begin
            do_wr(1'b1, 8'($urandom()) & 8'($urandom()), "R3 random mask");
         end else begin
            do_init(8'($urandom()), 1'($urandom()), 8'($urandom()) & 8'h92, "R2 random init");
         end
      end

      summary();
      $finish;
   end

endmodule